// File: doc/BRIEF.md
# Return Address Stack Unit

This block keeps a small hardware call stack for a processor core inside a fixed window of sixteen bytes, seen by the rest of the system at byte addresses 0x30 to 0x3F. A 4-bit stack pointer selects the byte at address 0x30 plus the pointer. The core hands the unit a 12-bit return address to save on a subroutine call or interrupt entry. On a return it asks for the saved address back, and the unit delivers it for the program counter.

Each save or restore moves two bytes, one per clock. The stack grows toward lower addresses. The pointer always names the next free byte. On a save the low byte goes first, into the byte the pointer names, and the high byte follows one byte lower. On a restore the high byte is read first from one above the pointer, then the low byte. Software may also write the pointer directly. Pointer arithmetic wraps modulo 16, with no overflow or underflow detection.

Control is a five-state machine:
- ST_IDLE waits for a request.
- ST_PUSH_LO writes the low byte.
- ST_PUSH_HI writes the high byte and raises `done_o`.
- ST_PULL_HI reads and holds the high byte.
- ST_PULL_LO reads the low byte and presents the full address with `done_o` and `ret_valid_o`.

The transitions are:
- IDLE to PUSH_LO on an accepted push.
- IDLE to PULL_HI on an accepted pull.
- PUSH_LO to PUSH_HI and PULL_HI to PULL_LO unconditionally.
- PUSH_HI and PULL_LO back to IDLE unconditionally.
- IDLE to IDLE otherwise, including on a pointer load.

Top module: `ret_stack_unit`

## Requirements
- R1: After reset the pointer reads 0xF, `busy_o` and `done_o` are 0, and every byte of the window is 0x00.
- R2: A push of address A occupies two cycles. In the first cycle the unit writes A[7:0] at pointer P. In the second it writes the high byte at P-1 and raises `done_o`. The pointer ends at P-2.
- R3: The high byte holds A[11:8] in bits 3:0, and its bits 7:4 are stored as zero.
- R4: A pull from pointer P occupies two cycles. It reads the high byte at P+1, then the low byte at P+2, and the pointer ends at P+2. In the second cycle `done_o` and `ret_valid_o` are 1 and `ret_addr_o` equals {byte(P+1)[3:0], byte(P+2)}.
- R5: All pointer arithmetic wraps modulo 16, so 0xF+1 gives 0x0 and 0x0-1 gives 0xF.
- R6: With the unit idle, `sp_load_i` high writes `sp_load_val_i` into the pointer at the next clock edge. Any value from 0 to 15 is accepted.
- R7: A request is taken only in ST_IDLE, with priority pointer load over push over pull; a request that loses is dropped. While busy, pushes, pulls and pointer loads are ignored.
- R8: `busy_o` is high exactly for the two cycles of a transfer. `done_o` is high for one cycle only, the second cycle of that transfer.
- R9: Addresses pushed in sequence come back in reverse order, and a balanced sequence of pushes and pulls returns the pointer to its starting value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| push_req_i | input | 1 | Request to save `push_addr_i` |
| push_addr_i | input | 12 | Return address to save, sampled when a push is accepted |
| pull_req_i | input | 1 | Request to restore the top address |
| sp_load_i | input | 1 | Write `sp_load_val_i` into the pointer |
| sp_load_val_i | input | 4 | New pointer value |
| busy_o | output | 1 | A transfer is in progress |
| done_o | output | 1 | Final cycle of a push or pull |
| ret_valid_o | output | 1 | `ret_addr_o` holds a restored address |
| ret_addr_o | output | 12 | Restored return address |
| sp_o | output | 4 | Current stack pointer |

## Verification
The bench loads the pointer to offsets that straddle a saved frame and then pulls. This exposes each byte separately. A design that swapped the low and high bytes, or that left junk in the top nibble of the high byte, would return the wrong value. Saves and restores that cross the 0xF/0x0 boundary catch arithmetic that saturates or spills into a fifth bit. Simultaneous requests and requests issued mid-transfer catch a wrong priority order, or a machine that restarts or moves the pointer while busy; either would leave the pointer off by two or more. Three nested saves returned in reverse order catch any pointer step other than two.

// File: rtl/rsu_pkg.sv
package rsu_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_PUSH_LO = 3'd1,
        ST_PUSH_HI = 3'd2,
        ST_PULL_HI = 3'd3,
        ST_PULL_LO = 3'd4
    } rsu_state_e;

endpackage

// File: rtl/rsu_fsm.sv
module rsu_fsm
    import rsu_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       push_req,
    input  logic       pull_req,
    input  logic       sp_load,
    output rsu_state_e state,
    output logic       take_load,
    output logic       take_push,
    output logic       busy,
    output logic       done
);

    rsu_state_e state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state;
        unique case (state)
            ST_IDLE: begin
                if (sp_load)       state_d = ST_IDLE;
                else if (push_req) state_d = ST_PUSH_LO;
                else if (pull_req) state_d = ST_PULL_HI;
            end
            ST_PUSH_LO: state_d = ST_PUSH_HI;
            ST_PUSH_HI: state_d = ST_IDLE;
            ST_PULL_HI: state_d = ST_PULL_LO;
            ST_PULL_LO: state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        take_load = 1'b0;
        take_push = 1'b0;
        busy      = 1'b1;
        done      = 1'b0;
        unique case (state)
            ST_IDLE: begin
                busy      = 1'b0;
                take_load = sp_load;
                take_push = !sp_load && push_req;
            end
            ST_PUSH_HI, ST_PULL_LO: done = 1'b1;
            default: ;
        endcase
    end

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R8
    AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(busy)); // R8
    AST_PUSH_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PUSH_LO) |=> (state == ST_PUSH_HI)); // R2
    AST_PULL_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PULL_HI) |=> (state == ST_PULL_LO)); // R4

endmodule

// File: rtl/rsu_ptr.sv
module rsu_ptr #(
    parameter int SP_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [SP_W-1:0] load_val,
    input  logic            dec,
    input  logic            inc,
    output logic [SP_W-1:0] sp
);

    localparam logic [SP_W-1:0] SP_RESET = {SP_W{1'b1}};
    localparam logic [SP_W-1:0] SP_ONE   = {{(SP_W-1){1'b0}}, 1'b1};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sp <= SP_RESET;
        end else if (load) begin
            sp <= load_val;
        end else if (dec) begin
            sp <= sp - SP_ONE;
        end else if (inc) begin
            sp <= sp + SP_ONE;
        end
    end

    AST_DEC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !load) |=> (sp == $past(sp) - SP_ONE)); // R5
    AST_INC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !load) |=> (sp == $past(sp) + SP_ONE)); // R5
    AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (sp == $past(load_val))); // R6

endmodule

// File: rtl/rsu_ram.sv
module rsu_ram #(
    parameter int SP_W   = 4,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [SP_W-1:0]   waddr,
    input  logic [BYTE_W-1:0] wdata,
    input  logic [SP_W-1:0]   raddr,
    output logic [BYTE_W-1:0] rdata
);

    localparam int DEPTH = 1 << SP_W;

    logic [BYTE_W-1:0] mem [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_byte
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mem[i] <= '0;
            end else if (we && (waddr == SP_W'(i))) begin
                mem[i] <= wdata;
            end
        end
    end

    assign rdata = mem[raddr];

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (mem[$past(waddr)] == $past(wdata))); // R2

endmodule

// File: rtl/ret_stack_unit.sv
module ret_stack_unit
    import rsu_pkg::*;
#(
    parameter int SP_W   = 4,
    parameter int ADDR_W = 12,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_req_i,
    input  logic [ADDR_W-1:0] push_addr_i,
    input  logic              pull_req_i,
    input  logic              sp_load_i,
    input  logic [SP_W-1:0]   sp_load_val_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              ret_valid_o,
    output logic [ADDR_W-1:0] ret_addr_o,
    output logic [SP_W-1:0]   sp_o
);

    localparam int HI_W  = ADDR_W - BYTE_W;
    localparam int PAD_W = BYTE_W - HI_W;
    localparam logic [SP_W-1:0] SP_ONE = {{(SP_W-1){1'b0}}, 1'b1};

    rsu_state_e        state;
    logic              take_load;
    logic              take_push;
    logic [ADDR_W-1:0] addr_q;
    logic [HI_W-1:0]   hi_q;
    logic              ram_we;
    logic [BYTE_W-1:0] ram_wdata;
    logic [SP_W-1:0]   ram_raddr;
    logic [BYTE_W-1:0] ram_rdata;
    logic              sp_dec;
    logic              sp_inc;

    rsu_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_req  (push_req_i),
        .pull_req  (pull_req_i),
        .sp_load   (sp_load_i),
        .state     (state),
        .take_load (take_load),
        .take_push (take_push),
        .busy      (busy_o),
        .done      (done_o)
    );

    assign sp_dec = (state == ST_PUSH_LO) || (state == ST_PUSH_HI);
    assign sp_inc = (state == ST_PULL_HI) || (state == ST_PULL_LO);

    rsu_ptr #(.SP_W(SP_W)) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (take_load),
        .load_val (sp_load_val_i),
        .dec      (sp_dec),
        .inc      (sp_inc),
        .sp       (sp_o)
    );

    // address capture and high byte hold
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            hi_q   <= '0;
        end else begin
            if (take_push) addr_q <= push_addr_i;
            if (state == ST_PULL_HI) hi_q <= ram_rdata[HI_W-1:0];
        end
    end

    always_comb begin
        ram_we    = sp_dec;
        ram_wdata = (state == ST_PUSH_HI) ? {{PAD_W{1'b0}}, addr_q[ADDR_W-1:BYTE_W]}
                                          : addr_q[BYTE_W-1:0];
        ram_raddr = sp_o + SP_ONE;
    end

    rsu_ram #(.SP_W(SP_W), .BYTE_W(BYTE_W)) u_ram (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (ram_we),
        .waddr (sp_o),
        .wdata (ram_wdata),
        .raddr (ram_raddr),
        .rdata (ram_rdata)
    );

    assign ret_valid_o = (state == ST_PULL_LO);
    assign ret_addr_o  = {hi_q, ram_rdata};

    AST_HI_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PUSH_HI) |-> (ram_wdata[BYTE_W-1:HI_W] == '0)); // R3
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !sp_load_i && !push_req_i && !pull_req_i) |=> $stable(sp_o)); // R7
    AST_BUSY_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && sp_load_i && (state == ST_PUSH_LO)) |=> (sp_o == $past(sp_o) - SP_ONE)); // R7
    AST_VALID_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        ret_valid_o |-> done_o); // R4

endmodule

// File: tb/ret_stack_unit_tb.sv
module ret_stack_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        push_req = 1'b0;
    logic [11:0] push_addr = '0;
    logic        pull_req = 1'b0;
    logic        sp_load = 1'b0;
    logic [3:0]  sp_load_val = '0;
    logic        busy, done, ret_valid;
    logic [11:0] ret_addr;
    logic [3:0]  sp;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    ret_stack_unit dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .push_req_i    (push_req),
        .push_addr_i   (push_addr),
        .pull_req_i    (pull_req),
        .sp_load_i     (sp_load),
        .sp_load_val_i (sp_load_val),
        .busy_o        (busy),
        .done_o        (done),
        .ret_valid_o   (ret_valid),
        .ret_addr_o    (ret_addr),
        .sp_o          (sp)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !finished) begin
            fails++;
            $display("FAIL watchdog: run did not finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic do_push(input logic [11:0] a);
        @(negedge clk); push_req = 1'b1; push_addr = a;
        @(negedge clk); push_req = 1'b0;
        chk("R8 busy first push cycle", busy, 1);
        chk("R8 no done first push cycle", done, 0);
        @(negedge clk);
        chk("R2 done second push cycle", done, 1);
        @(negedge clk);
        chk("R8 idle after push", busy, 0);
    endtask

    task automatic do_pull(output logic [11:0] got);
        @(negedge clk); pull_req = 1'b1;
        @(negedge clk); pull_req = 1'b0;
        chk("R8 no done first pull cycle", done, 0);
        @(negedge clk);
        chk("R4 done second pull cycle", done, 1);
        chk("R4 valid second pull cycle", ret_valid, 1);
        got = ret_addr;
        @(negedge clk);
        chk("R8 idle after pull", busy, 0);
    endtask

    task automatic load_sp(input logic [3:0] v);
        @(negedge clk); sp_load = 1'b1; sp_load_val = v;
        @(negedge clk); sp_load = 1'b0;
        chk("R6 pointer load", sp, v);
    endtask

    task automatic t_reset;
        logic [11:0] g;
        chk("R1 reset pointer", sp, 4'hF);
        chk("R1 reset busy", busy, 0);
        chk("R1 reset done", done, 0);
        load_sp(4'h3);
        do_pull(g);
        chk("R1 window cleared", g, 12'h000);
        load_sp(4'hF);
    endtask

    task automatic t_byte_order;
        logic [11:0] g;
        do_push(12'h5A3);
        chk("R2 pointer after push", sp, 4'hD);
        load_sp(4'hC);
        do_pull(g);
        chk("R2 high byte at P-1", g, 12'h005);
        load_sp(4'hE);
        do_pull(g);
        chk("R2 low byte at P", g, 12'h300);
        chk("R5 pull wraps pointer", sp, 4'h0);
    endtask

    task automatic t_upper_zero;
        logic [11:0] g;
        load_sp(4'hF);
        do_push(12'hFFF);
        load_sp(4'hC);
        do_pull(g);
        chk("R3 high byte upper bits zero", g, 12'h00F);
    endtask

    task automatic t_lifo;
        logic [11:0] g;
        load_sp(4'hF);
        do_push(12'h123);
        do_push(12'h456);
        do_push(12'h789);
        chk("R9 pointer after three pushes", sp, 4'h9);
        do_pull(g); chk("R9 first out", g, 12'h789);
        do_pull(g); chk("R9 second out", g, 12'h456);
        do_pull(g); chk("R9 third out", g, 12'h123);
        chk("R9 pointer balanced", sp, 4'hF);
    endtask

    task automatic t_wrap;
        logic [11:0] g;
        load_sp(4'h1);
        do_push(12'hBCD);
        chk("R5 push wraps pointer", sp, 4'hF);
        do_pull(g);
        chk("R5 wrapped frame returns", g, 12'hBCD);
        chk("R5 pointer back", sp, 4'h1);
    endtask

    task automatic t_priority;
        logic [11:0] g;
        load_sp(4'hB);
        @(negedge clk); push_req = 1'b1; pull_req = 1'b1; push_addr = 12'h777;
        @(negedge clk); push_req = 1'b0; pull_req = 1'b0;
        @(negedge clk); @(negedge clk);
        chk("R7 push beats pull", sp, 4'h9);
        do_pull(g);
        chk("R7 pushed value stored", g, 12'h777);
        @(negedge clk); sp_load = 1'b1; sp_load_val = 4'h6; push_req = 1'b1;
        @(negedge clk); sp_load = 1'b0; push_req = 1'b0;
        chk("R7 load beats push pointer", sp, 4'h6);
        chk("R7 load beats push idle", busy, 0);
    endtask

    task automatic t_busy_ignore;
        logic [11:0] g;
        load_sp(4'h8);
        @(negedge clk); push_req = 1'b1; push_addr = 12'h246;
        @(negedge clk); push_req = 1'b0; sp_load = 1'b1; sp_load_val = 4'h3; pull_req = 1'b1;
        @(negedge clk);
        @(negedge clk); sp_load = 1'b0; pull_req = 1'b0;
        chk("R7 busy ignores load and pull", sp, 4'h6);
        @(negedge clk);
        chk("R7 no pull started", busy, 0);
        do_pull(g);
        chk("R7 frame intact", g, 12'h246);
        chk("R7 pointer restored", sp, 4'h8);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_byte_order();
        t_upper_zero();
        t_lifo();
        t_wrap();
        t_priority();
        t_busy_ignore();
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule